// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block is the architectural register file of a register-oriented scientific processor in which no load or store instruction exists. It holds three banks of eight registers: address registers and index registers of 18 bits each, and operand registers of 60 bits each. A write of an address into one of the address registers numbered 1 through 7 is itself the memory operation. Numbers 1 to 5 fetch the addressed word into the operand register with the same number. Numbers 6 and 7 send the operand register with the same number out to that address.

Three write ports, each tagged with a bank code, and three combinational read ports face the execution side. A single memory request channel with a valid/ready request and a one-cycle response pulse faces the memory side. Only one implicit transaction is in flight at a time. While one is open, further triggering address writes are refused through a per-port acknowledge, and the issuing logic must retry them. A read of an operand register whose fetch is still open reports not-ready. Index register 0 always reads as zero.

Top module: `addr_trig_regfile`

## Requirements
- R1: While rst_n is low, every register is cleared, busy is low and mem_req_valid is low. After reset every read port returns data 0 with ready 1.
- R2: Bank codes are 0 address, 1 index, 2 operand, 3 none. Address and index writes keep the low 18 bits of the write data, and reads of them are zero-extended to 60 bits. Bank code 3 reads 0 with ready 1 and writes nothing. A written value is visible on the read ports in the cycle after the write edge.
- R3: A write to index register 0 is acknowledged, and that register always reads 0.
- R4: An accepted write to address register 1..5 raises mem_req_valid in the next cycle, with mem_req_we 0 and mem_req_addr equal to the written value. The response data lands in the same-numbered operand register and is readable in the cycle after the response pulse.
- R5: An accepted write to address register 6 or 7 issues a request with mem_req_we 1. mem_req_wdata is the same-numbered operand register's value as it stood before the accepting edge, so a same-cycle port write to it is not included.
- R6: A write to address register 0 is stored but starts no request, and busy stays low.
- R7: busy is high from the cycle after a triggering write is accepted until the cycle after the response pulse. While busy, a triggering write gets wr_ack 0 and changes nothing. Non-triggering writes are always acknowledged when wr_en is high, and wr_ack is 0 when wr_en is low.
- R8: While mem_req_valid is high and mem_req_ready is low, the request and its fields stay unchanged.
- R9: While a fetch into operand register n is open, a read of operand register n returns ready 0 and data 0. Reads of all other registers are unaffected.
- R10: Among triggering writes in the same idle cycle, only the lowest-numbered port is accepted. When accepted writes hit the same register, the highest-numbered port's value is kept.
- R11: If the response pulse and a port write target the same operand register in one cycle, the response data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 3 | Per-port write request |
| wr_bank | input | 3x2 | Per-port bank code |
| wr_idx | input | 3x3 | Per-port register number |
| wr_data | input | 3x60 | Per-port write data |
| wr_ack | output | 3 | Per-port write accepted this cycle |
| rd_bank | input | 3x2 | Per-port read bank code |
| rd_idx | input | 3x3 | Per-port read register number |
| rd_data | output | 3x60 | Per-port read data |
| rd_ready | output | 3 | Read data is current |
| busy | output | 1 | An implicit memory transaction is open |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 store, 0 load |
| mem_req_addr | output | 18 | Word address |
| mem_req_wdata | output | 60 | Store data |
| mem_rsp_valid | input | 1 | One-cycle completion pulse |
| mem_rsp_rdata | input | 60 | Load data, valid with the pulse |

## Verification
The properties assume a memory side that sends exactly one response pulse per request, only after the request handshake and never while the block is idle or still presenting the request. The bench's responder sees each handshake and answers it once after a chosen latency, so it stays inside that contract even when it stalls ready at random. The properties also assume that the write ports are free to repeat a refused triggering write. The stimulus applies every port write for exactly one cycle and lets the reference model decide whether it was taken.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
// rf_pkg: shared encodings for the address-triggered register file.
// Assumes bank codes are fixed at two bits and that every user imports this package.
package rf_pkg;
    typedef enum logic [1:0] {
        BANK_A    = 2'd0,
        BANK_B    = 2'd1,
        BANK_X    = 2'd2,
        BANK_NONE = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_e;
endpackage

// File: rtl/rf_write_arb.sv
`timescale 1ns/1ps
// rf_write_arb: decides which write ports are acknowledged this cycle.
// Picks the lowest-numbered triggering address write when the sequencer is idle.
// Refuses every other triggering write.
// Assumes register 0 of the address bank never triggers.
module rf_write_arb
    import rf_pkg::*;
#(
    parameter int NWP  = 3,
    parameter int IDXW = 3,
    parameter int PW   = 2
) (
    input  logic                      idle,
    input  logic [NWP-1:0]            wr_en,
    input  logic [NWP-1:0][1:0]       wr_bank,
    input  logic [NWP-1:0][IDXW-1:0]  wr_idx,
    output logic [NWP-1:0]            wr_ack,
    output logic                      trig_go,
    output logic [PW-1:0]             trig_port
);
    logic [NWP-1:0] trig;
    logic           any_trig;

    // Flag each port that carries a triggering address write.
    for (genvar p = 0; p < NWP; p++) begin : g_trig
        assign trig[p] = wr_en[p] && (bank_e'(wr_bank[p]) == BANK_A) && (wr_idx[p] != '0);
    end

    // Find the lowest-numbered triggering port.
    always_comb begin
        any_trig  = 1'b0;
        trig_port = '0;
        for (int p = NWP - 1; p >= 0; p--) begin
            if (trig[p]) begin
                any_trig  = 1'b1;
                trig_port = PW'(p);
            end
        end
    end

    assign trig_go = idle && any_trig;

    // Acknowledge plain writes always; a triggering write only if it is the chosen one.
    for (genvar p = 0; p < NWP; p++) begin : g_ack
        assign wr_ack[p] = wr_en[p] && (!trig[p] || (trig_go && (trig_port == PW'(p))));
    end
endmodule

// File: rtl/rf_mem_seq.sv
`timescale 1ns/1ps
// rf_mem_seq: runs one implicit memory transaction at a time.
// It captures the address, the direction and the store data on start.
// It holds the request until ready, then waits for the response pulse.
// Assumes the response pulse never arrives before the request handshake.
module rf_mem_seq
    import rf_pkg::*;
#(
    parameter int AW       = 18,
    parameter int XW       = 60,
    parameter int IDXW     = 3,
    parameter int ST_FIRST = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IDXW-1:0] start_idx,
    input  logic [AW-1:0]   start_addr,
    input  logic [XW-1:0]   start_wdata,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic [XW-1:0]   mem_rsp_rdata,
    output logic            idle,
    output logic            mem_req_valid,
    output logic            mem_req_we,
    output logic [AW-1:0]   mem_req_addr,
    output logic [XW-1:0]   mem_req_wdata,
    output logic            pend_load,
    output logic [IDXW-1:0] pend_idx,
    output logic            ld_done,
    output logic [XW-1:0]   ld_data
);
    seq_e state_q;

    // Advance the transaction state and capture the request fields on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= SEQ_IDLE;
            pend_idx      <= '0;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q       <= SEQ_REQ;
                    pend_idx      <= start_idx;
                    mem_req_we    <= (start_idx >= IDXW'(ST_FIRST));
                    mem_req_addr  <= start_addr;
                    mem_req_wdata <= start_wdata;
                end
                SEQ_REQ:  if (mem_req_ready) state_q <= SEQ_WAIT;
                SEQ_WAIT: if (mem_rsp_valid) state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign idle          = (state_q == SEQ_IDLE);
    assign mem_req_valid = (state_q == SEQ_REQ);
    assign pend_load     = !idle && !mem_req_we;
    assign ld_done       = (state_q == SEQ_WAIT) && mem_rsp_valid && !mem_req_we;
    assign ld_data       = mem_rsp_rdata;
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
// rf_read_port: one combinational read port over the three banks.
// Zero-extends address and index values, forces index 0 to zero, and masks an operand register that is still being fetched.
// Assumes NREG equals 2**IDXW.
module rf_read_port
    import rf_pkg::*;
#(
    parameter int AW   = 18,
    parameter int XW   = 60,
    parameter int NREG = 8,
    parameter int IDXW = 3
) (
    input  logic [NREG-1:0][AW-1:0] a_regs,
    input  logic [NREG-1:0][AW-1:0] b_regs,
    input  logic [NREG-1:0][XW-1:0] x_regs,
    input  logic                    pend_load,
    input  logic [IDXW-1:0]         pend_idx,
    input  logic [1:0]              rd_bank,
    input  logic [IDXW-1:0]         rd_idx,
    output logic [XW-1:0]           rd_data,
    output logic                    rd_ready
);
    // Select the addressed register and decide whether its value is current.
    always_comb begin
        rd_ready = 1'b1;
        rd_data  = '0;
        unique case (bank_e'(rd_bank))
            BANK_A: rd_data = {{(XW-AW){1'b0}}, a_regs[rd_idx]};
            BANK_B: rd_data = (rd_idx == '0) ? '0 : {{(XW-AW){1'b0}}, b_regs[rd_idx]};
            BANK_X: begin
                if (pend_load && (pend_idx == rd_idx)) rd_ready = 1'b0;
                else                                   rd_data  = x_regs[rd_idx];
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/addr_trig_regfile.sv
`timescale 1ns/1ps
// addr_trig_regfile: three banks of eight registers in which address
// writes 1..7 start an implicit load (1..ST_FIRST-1) or store
// (ST_FIRST..NREG-1) on the paired operand register.
// Assumes one memory response per request and single-cycle port writes.
module addr_trig_regfile
    import rf_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int AW       = 18,
    parameter int XW       = 60,
    parameter int NWP      = 3,
    parameter int NRP      = 3,
    parameter int ST_FIRST = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NWP-1:0]                        wr_en,
    input  logic [NWP-1:0][1:0]                   wr_bank,
    input  logic [NWP-1:0][$clog2(NREG)-1:0]      wr_idx,
    input  logic [NWP-1:0][XW-1:0]                wr_data,
    output logic [NWP-1:0]                        wr_ack,
    input  logic [NRP-1:0][1:0]                   rd_bank,
    input  logic [NRP-1:0][$clog2(NREG)-1:0]      rd_idx,
    output logic [NRP-1:0][XW-1:0]                rd_data,
    output logic [NRP-1:0]                        rd_ready,
    output logic                                  busy,
    output logic                                  mem_req_valid,
    input  logic                                  mem_req_ready,
    output logic                                  mem_req_we,
    output logic [AW-1:0]                         mem_req_addr,
    output logic [XW-1:0]                         mem_req_wdata,
    input  logic                                  mem_rsp_valid,
    input  logic [XW-1:0]                         mem_rsp_rdata
);
    localparam int IDXW = $clog2(NREG);
    localparam int PW   = (NWP > 1) ? $clog2(NWP) : 1;

    logic [NREG-1:0][AW-1:0] a_q;
    logic [NREG-1:0][AW-1:0] b_q;
    logic [NREG-1:0][XW-1:0] x_q;
    logic [NWP-1:0][AW-1:0]  wr_low;

    logic            idle, trig_go, pend_load, ld_done;
    logic [PW-1:0]   trig_port;
    logic [IDXW-1:0] pend_idx;
    logic [XW-1:0]   ld_data;

    // Narrow view of each port's data for the 18-bit banks.
    for (genvar p = 0; p < NWP; p++) begin : g_low
        assign wr_low[p] = wr_data[p][AW-1:0];
    end

    rf_write_arb #(.NWP(NWP), .IDXW(IDXW), .PW(PW)) u_arb (
        .idle      (idle),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .wr_ack    (wr_ack),
        .trig_go   (trig_go),
        .trig_port (trig_port)
    );

    rf_mem_seq #(.AW(AW), .XW(XW), .IDXW(IDXW), .ST_FIRST(ST_FIRST)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (trig_go),
        .start_idx     (wr_idx[trig_port]),
        .start_addr    (wr_low[trig_port]),
        .start_wdata   (x_q[wr_idx[trig_port]]),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .idle          (idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .pend_load     (pend_load),
        .pend_idx      (pend_idx),
        .ld_done       (ld_done),
        .ld_data       (ld_data)
    );

    // Apply acknowledged port writes in port order, then the load response on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            x_q <= '0;
        end else begin
            for (int p = 0; p < NWP; p++) begin
                if (wr_ack[p]) begin
                    unique case (bank_e'(wr_bank[p]))
                        BANK_A:  a_q[wr_idx[p]] <= wr_low[p];
                        BANK_B:  if (wr_idx[p] != '0) b_q[wr_idx[p]] <= wr_low[p];
                        BANK_X:  x_q[wr_idx[p]] <= wr_data[p];
                        default: ;
                    endcase
                end
            end
            if (ld_done) x_q[pend_idx] <= ld_data;
        end
    end

    for (genvar r = 0; r < NRP; r++) begin : g_rd
        rf_read_port #(.AW(AW), .XW(XW), .NREG(NREG), .IDXW(IDXW)) u_rd (
            .a_regs    (a_q),
            .b_regs    (b_q),
            .x_regs    (x_q),
            .pend_load (pend_load),
            .pend_idx  (pend_idx),
            .rd_bank   (rd_bank[r]),
            .rd_idx    (rd_idx[r]),
            .rd_data   (rd_data[r]),
            .rd_ready  (rd_ready[r])
        );
    end

    assign busy = !idle;
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
// rf_checker: temporal properties of addr_trig_regfile, attached by bind.
// Assumes the memory side answers each request once, after its handshake.
module rf_checker #(
    parameter int NREG     = 8,
    parameter int AW       = 18,
    parameter int XW       = 60,
    parameter int NWP      = 3,
    parameter int NRP      = 3,
    parameter int ST_FIRST = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NWP-1:0]                   wr_en,
    input logic [NWP-1:0][1:0]              wr_bank,
    input logic [NWP-1:0][$clog2(NREG)-1:0] wr_idx,
    input logic [NWP-1:0][AW-1:0]           wr_low,
    input logic [NWP-1:0]                   wr_ack,
    input logic [NRP-1:0][1:0]              rd_bank,
    input logic [NRP-1:0][$clog2(NREG)-1:0] rd_idx,
    input logic [NRP-1:0][XW-1:0]           rd_data,
    input logic                             busy,
    input logic                             mem_req_valid,
    input logic                             mem_req_ready,
    input logic                             mem_req_we,
    input logic [AW-1:0]                    mem_req_addr,
    input logic [XW-1:0]                    mem_req_wdata,
    input logic                             mem_rsp_valid
);
    localparam int IDXW = $clog2(NREG);

    logic [NWP-1:0] trig_c;
    logic           rst_seen;

    // Triggering writes as seen from the ports.
    for (genvar p = 0; p < NWP; p++) begin : g_tc
        assign trig_c[p] = wr_en[p] && (wr_bank[p] == 2'd0) && (wr_idx[p] != '0);
    end

    // Remember that a reset edge has passed, so the reset check skips time zero.
    always_ff @(posedge clk) rst_seen <= rst_seen || !rst_n;

    // R1: no request is presented while reset is held.
    always @(posedge clk) begin
        if (rst_seen && !rst_n) p_rst_quiet_r1: assert (!mem_req_valid && !busy);
    end

    for (genvar r = 0; r < NRP; r++) begin : g_rp
        p_b0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_bank[r] == 2'd1 && rd_idx[r] == '0) |-> rd_data[r] == '0);
    end

    for (genvar p = 0; p < NWP; p++) begin : g_wp
        p_start_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ack[p] && trig_c[p]) |=> (mem_req_valid && mem_req_addr == $past(wr_low[p])));
        p_store_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ack[p] && trig_c[p]) |=> (mem_req_we == ($past(wr_idx[p]) >= IDXW'(ST_FIRST))));
    end

    p_a0_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ((wr_ack & trig_c) == '0)) |=> (!busy && !mem_req_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((wr_ack & trig_c) == '0));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req_valid && mem_rsp_valid) |=> !busy);

    p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

    p_one_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_ack & trig_c) <= 1);
endmodule

bind addr_trig_regfile rf_checker #(
    .NREG(NREG), .AW(AW), .XW(XW), .NWP(NWP), .NRP(NRP), .ST_FIRST(ST_FIRST)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_bank       (wr_bank),
    .wr_idx        (wr_idx),
    .wr_low        (wr_low),
    .wr_ack        (wr_ack),
    .rd_bank       (rd_bank),
    .rd_idx        (rd_idx),
    .rd_data       (rd_data),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/addr_trig_regfile_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, a memory
// responder, directed corner cases and a random phase.
module addr_trig_regfile_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic [2:0]       wr_en;
    logic [2:0][1:0]  wr_bank;
    logic [2:0][2:0]  wr_idx;
    logic [2:0][59:0] wr_data;
    logic [2:0]       wr_ack;
    logic [2:0][1:0]  rd_bank;
    logic [2:0][2:0]  rd_idx;
    logic [2:0][59:0] rd_data;
    logic [2:0]       rd_ready;
    logic busy, mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
    logic [17:0] mem_req_addr;
    logic [59:0] mem_req_wdata, mem_rsp_rdata;

    always #(CLK_P/2) clk = ~clk;

    addr_trig_regfile u_addr_trig_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_ready(rd_ready), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    // Reference model state.
    logic [17:0] m_a [8];
    logic [17:0] m_b [8];
    logic [59:0] m_x [8];
    int          m_ph;       // 0 idle, 1 presenting request, 2 awaiting response
    int          m_pidx;
    logic [17:0] m_paddr;
    bit          m_pwe;
    logic [59:0] m_pwdata;

    // Memory responder state.
    logic [59:0] mem [int];
    bit          rs_pend = 0;
    int          rs_cnt = 0, rs_lat = 2, rdy_mode = 0;
    logic [59:0] rs_data;
    bit          hook_en = 0;

    function automatic logic [59:0] memfn(input logic [17:0] a);
        return {a ^ 18'h2A5A5, 6'h3C, a, ~a};
    endfunction

    function automatic bit is_trig(input int p);
        return wr_en[p] && wr_bank[p] == 2'd0 && wr_idx[p] != 3'd0;
    endfunction

    function automatic logic [2:0] exp_ack();
        int first = -1;
        logic [2:0] r = '0;
        for (int p = 2; p >= 0; p--) if (is_trig(p)) first = p;
        for (int p = 0; p < 3; p++)
            r[p] = wr_en[p] && (!is_trig(p) || (m_ph == 0 && p == first));
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [59:0] act, input logic [59:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Model step at each rising edge, plus responder bookkeeping.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_a[i] = '0; m_b[i] = '0; m_x[i] = '0; end
            m_ph = 0; m_pidx = 0; m_paddr = '0; m_pwe = 0; m_pwdata = '0;
            rs_pend = 0;
        end else begin
            logic [2:0] ack;
            logic [59:0] xold [8];
            bit ld;
            int tp;
            ack = exp_ack();
            tp = -1;
            for (int p = 2; p >= 0; p--) if (ack[p] && is_trig(p)) tp = p;
            for (int i = 0; i < 8; i++) xold[i] = m_x[i];
            ld = (m_ph == 2) && mem_rsp_valid && !m_pwe;
            if (m_ph == 1 && mem_req_ready) m_ph = 2;
            else if (m_ph == 2 && mem_rsp_valid) m_ph = 0;
            else if (m_ph == 0 && tp >= 0) begin
                m_ph = 1; m_pidx = int'(wr_idx[tp]); m_paddr = wr_data[tp][17:0];
                m_pwe = (wr_idx[tp] >= 3'd6); m_pwdata = xold[wr_idx[tp]];
            end
            for (int p = 0; p < 3; p++) if (ack[p]) begin
                case (wr_bank[p])
                    2'd0: m_a[wr_idx[p]] = wr_data[p][17:0];
                    2'd1: if (wr_idx[p] != 3'd0) m_b[wr_idx[p]] = wr_data[p][17:0];
                    2'd2: m_x[wr_idx[p]] = wr_data[p];
                    default: ;
                endcase
            end
            if (ld) m_x[m_pidx] = mem_rsp_rdata;
            if (mem_rsp_valid) rs_pend = 0;
            if (mem_req_valid && mem_req_ready) begin
                rs_pend = 1;
                if (rdy_mode == 1) rs_lat = int'($urandom % 3);
                rs_cnt = rs_lat;
                if (mem_req_we) mem[int'(mem_req_addr)] = mem_req_wdata;
                rs_data = mem.exists(int'(mem_req_addr)) ? mem[int'(mem_req_addr)] : memfn(mem_req_addr);
            end
        end
    end

    task automatic compare_all();
        logic [2:0] ea;
        ea = exp_ack();
        chk(wr_ack === ea, "R10 wr_ack vs model", {57'd0, wr_ack}, {57'd0, ea});
        chk(busy === (m_ph != 0), "R7 busy vs model", {59'd0, busy}, {59'd0, m_ph != 0});
        chk(mem_req_valid === (m_ph == 1), "R4 req_valid vs model", {59'd0, mem_req_valid}, {59'd0, m_ph == 1});
        if (m_ph == 1) begin
            chk(mem_req_addr === m_paddr, "R4 req_addr vs model", {42'd0, mem_req_addr}, {42'd0, m_paddr});
            chk(mem_req_we === m_pwe, "R5 req_we vs model", {59'd0, mem_req_we}, {59'd0, m_pwe});
            if (m_pwe) chk(mem_req_wdata === m_pwdata, "R5 req_wdata vs model", mem_req_wdata, m_pwdata);
        end
        for (int r = 0; r < 3; r++) begin
            logic [59:0] ed;
            bit er;
            er = 1; ed = '0;
            case (rd_bank[r])
                2'd0: ed = {42'd0, m_a[rd_idx[r]]};
                2'd1: ed = {42'd0, m_b[rd_idx[r]]};
                2'd2: if (m_ph != 0 && !m_pwe && m_pidx == int'(rd_idx[r])) er = 0;
                      else ed = m_x[rd_idx[r]];
                default: ;
            endcase
            chk(rd_ready[r] === er, "R9 rd_ready vs model", {59'd0, rd_ready[r]}, {59'd0, er});
            chk(rd_data[r] === ed, "R2 rd_data vs model", rd_data[r], ed);
        end
    endtask

    // One clock: drive the responder, compare, advance to the next falling edge.
    task automatic cyc();
        case (rdy_mode)
            0: mem_req_ready = 1'b1;
            1: mem_req_ready = ($urandom % 3) != 0;
            default: mem_req_ready = 1'b0;
        endcase
        mem_rsp_valid = 1'b0;
        if (rs_pend) begin
            if (rs_cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_rdata = rs_data; end
            else rs_cnt--;
        end
        if (hook_en && mem_rsp_valid) begin
            wr_en[0] = 1; wr_bank[0] = 2'd2; wr_idx[0] = 3'd5; wr_data[0] = 60'hBAD;
            hook_en = 0;
        end
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic clr_ports();
        wr_en = '0;
    endtask

    task automatic wp(input int p, input logic [1:0] bk, input logic [2:0] ix, input logic [59:0] d);
        wr_en[p] = 1; wr_bank[p] = bk; wr_idx[p] = ix; wr_data[p] = d;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 200) begin clr_ports(); cyc(); n++; end
        clr_ports();
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] bk, input logic [2:0] ix,
                          input logic [59:0] exp, input bit exp_rdy);
        rd_bank[0] = bk; rd_idx[0] = ix; #1;
        chk(rd_ready[0] === exp_rdy, {tag, " ready"}, {59'd0, rd_ready[0]}, {59'd0, exp_rdy});
        chk(rd_data[0] === exp, {tag, " data"}, rd_data[0], exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL R7 watchdog expired act=running exp=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [59:0] v6;
        rst_n = 0; wr_en = '0; wr_bank = '0; wr_idx = '0; wr_data = '0;
        rd_bank = '0; rd_idx = '0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = '0;
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        // R1: every bank reads zero after reset.
        rd_chk("R1 A7 after reset", 2'd0, 3'd7, '0, 1);
        rd_chk("R1 B5 after reset", 2'd1, 3'd5, '0, 1);
        rd_chk("R1 X3 after reset", 2'd2, 3'd3, '0, 1);
        // Fill operand registers.
        wp(0, 2'd2, 3'd1, 60'h111111111111111); wp(1, 2'd2, 3'd2, 60'h222222222222222);
        wp(2, 2'd2, 3'd3, 60'h333333333333333); cyc(); clr_ports();
        v6 = 60'hABCDEF012345678;
        wp(0, 2'd2, 3'd4, 60'h444); wp(1, 2'd2, 3'd5, 60'h555); wp(2, 2'd2, 3'd6, v6); cyc(); clr_ports();
        // R3: B0 write acknowledged but reads zero; R2: truncation and zero-extension.
        wp(0, 2'd2, 3'd7, 60'h777); wp(1, 2'd1, 3'd1, 60'h11); wp(2, 2'd1, 3'd0, 60'h5);
        #1; chk(wr_ack[2] === 1'b1, "R3 B0 write acknowledged", {59'd0, wr_ack[2]}, 60'd1);
        cyc(); clr_ports();
        rd_chk("R3 B0 reads zero", 2'd1, 3'd0, '0, 1);
        rd_chk("R2 B1 readback", 2'd1, 3'd1, 60'h11, 1);
        wp(0, 2'd1, 3'd2, 60'hFFFFFFFFFFFFFFF); cyc(); clr_ports();
        rd_chk("R2 B2 truncated", 2'd1, 3'd2, 60'h3FFFF, 1);
        rd_chk("R2 bank 3 reads zero", 2'd3, 3'd2, '0, 1);
        // R6: A0 starts nothing.
        wp(1, 2'd0, 3'd0, 60'h155); cyc(); clr_ports();
        chk(busy === 1'b0 && mem_req_valid === 1'b0, "R6 A0 write no request",
            {58'd0, busy, mem_req_valid}, '0);
        rd_chk("R6 A0 stored", 2'd0, 3'd0, 60'h155, 1);
        // R4 / R9: load into X2.
        wp(0, 2'd0, 3'd2, 60'h123); cyc(); clr_ports();
        chk(mem_req_valid === 1 && mem_req_we === 0 && mem_req_addr === 18'h123, "R4 load request",
            {40'd0, mem_req_valid, mem_req_we, mem_req_addr}, {40'd0, 2'b10, 18'h123});
        rd_chk("R9 X2 pending", 2'd2, 3'd2, '0, 0);
        rd_chk("R9 X3 unaffected", 2'd2, 3'd3, 60'h333333333333333, 1);
        wait_idle();
        rd_chk("R4 X2 loaded", 2'd2, 3'd2, memfn(18'h123), 1);
        // R8 / R7: stalled request, refused trigger while busy.
        rdy_mode = 2;
        wp(0, 2'd0, 3'd1, 60'h777); cyc(); clr_ports();
        cyc(); cyc();
        chk(mem_req_valid === 1 && mem_req_addr === 18'h777, "R8 request held",
            {41'd0, mem_req_valid, mem_req_addr}, {41'd0, 1'b1, 18'h777});
        wp(0, 2'd0, 3'd4, 60'h444); wp(1, 2'd1, 3'd4, 60'h44);
        #1; chk(wr_ack[1:0] === 2'b10, "R7 trigger refused while busy", {58'd0, wr_ack[1:0]}, 60'd2);
        cyc(); clr_ports();
        rd_chk("R7 A4 unchanged", 2'd0, 3'd4, '0, 1);
        rd_chk("R7 B4 written while busy", 2'd1, 3'd4, 60'h44, 1);
        rdy_mode = 0;
        wait_idle();
        rd_chk("R4 X1 loaded", 2'd2, 3'd1, memfn(18'h777), 1);
        // R5: store samples X6 before a same-cycle write to it.
        wp(0, 2'd0, 3'd6, 60'h400); wp(1, 2'd2, 3'd6, 60'h666); cyc(); clr_ports();
        chk(mem_req_we === 1 && mem_req_wdata === v6, "R5 store data is old X6", mem_req_wdata, v6);
        wait_idle();
        wp(0, 2'd0, 3'd3, 60'h400); cyc(); clr_ports(); wait_idle();
        rd_chk("R5 stored word read back", 2'd2, 3'd3, v6, 1);
        rd_chk("R5 X6 new value", 2'd2, 3'd6, 60'h666, 1);
        // R10: lowest triggering port wins; highest port wins a collision.
        wp(0, 2'd2, 3'd0, 60'h9); wp(1, 2'd0, 3'd4, 60'h010); wp(2, 2'd0, 3'd7, 60'h020);
        #1; chk(wr_ack === 3'b011, "R10 lowest trigger accepted", {57'd0, wr_ack}, 60'd3);
        cyc(); clr_ports();
        chk(mem_req_addr === 18'h010 && mem_req_we === 0, "R10 chosen request",
            {41'd0, mem_req_we, mem_req_addr}, {41'd0, 1'b0, 18'h010});
        wait_idle();
        rd_chk("R10 A7 unchanged", 2'd0, 3'd7, '0, 1);
        wp(0, 2'd1, 3'd3, 60'h111); wp(2, 2'd1, 3'd3, 60'h333); cyc(); clr_ports();
        rd_chk("R10 collision keeps port 2", 2'd1, 3'd3, 60'h333, 1);
        // R11: response beats a same-cycle port write.
        wp(0, 2'd0, 3'd5, 60'h055); cyc(); clr_ports();
        hook_en = 1;
        wait_idle();
        rd_chk("R11 response wins over port write", 2'd2, 3'd5, memfn(18'h055), 1);
        // Random phase, compared against the model every clock.
        rdy_mode = 1;
        for (int c = 0; c < 600; c++) begin
            for (int p = 0; p < 3; p++) begin
                wr_en[p]   = ($urandom % 3) == 0;
                wr_bank[p] = 2'($urandom % 4);
                wr_idx[p]  = 3'($urandom % 8);
                wr_data[p] = {28'($urandom), 32'($urandom)};
                rd_bank[p] = 2'($urandom % 4);
                rd_idx[p]  = 3'($urandom % 8);
            end
            cyc();
        end
        clr_ports();
        rdy_mode = 0;
        wait_idle();
        // R1: reset clears registers again.
        rst_n = 0; cyc(); cyc(); rst_n = 1;
        chk(busy === 0 && mem_req_valid === 0, "R1 reset quiet", {58'd0, busy, mem_req_valid}, '0);
        rd_chk("R1 X5 cleared", 2'd2, 3'd5, '0, 1);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule